// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words for a dual-channel frequency synthesizer over a three-wire serial link: a data line, a serial clock and a load strobe. All three wires are asynchronous to the system clock. They are first brought into the system clock domain. Edges of the serial clock and of the load strobe are then found by comparing successive synchronized samples.

Each rising serial-clock edge shifts one data bit into a 23-bit shift register. A word is sent most significant bit first, so word bit 23 goes in first and word bit 1 goes in last. A rising edge of the load strobe hands the register contents to one of four latch sets. Two control bits at the bottom of the word choose the set:

- a reference-divider set for channel 0 or channel 1;
- a feedback-divider set for channel 0 or channel 1.

Each set has its own field layout. Only the addressed set can change. A word whose divider values are illegal is refused: the addressed set keeps its contents and an error flag is raised. All latched fields are presented as parallel outputs, packed by channel. Channel c occupies slice `[c*W +: W]` of each output.

Top module: `cfg_serial_loader`

## Requirements
- R1: After a synchronous active-low reset, every latched field output of both channels is zero and `load_err_o` is 0.
- R2: The shift register holds 23 bits and takes one bit per rising serial-clock edge. If more than 23 bits are sent before a load, only the last 23 are kept; the last bit sent is word bit 1.
- R3: On a rising load edge, word bit 1 (channel select) and word bit 2 (kind) address the target. Bit2,bit1 = 0,0 selects the channel 0 reference set, 0,1 the channel 1 reference set, 1,0 the channel 0 feedback set, and 1,1 the channel 1 feedback set.
- R4: In a reference word, bits 3–19 carry the fields and bits 20–23 are ignored. The fields are:
  - bit 3 → `ref_mon_o` bit 0 and bit 4 → `ref_mon_o` bit 1;
  - bits 5–18 → `ref_ratio_o`, with bit 5 as the LSB;
  - bit 19 → `ref_cs_o`.
- R5: In a feedback word, the fields are:
  - bit 3 → `fb_lds_o`;
  - bit 4 → `fb_presc_o`;
  - bit 5 → `fb_phase_o`;
  - bits 6–12 → `fb_swallow_o`, with bit 6 as the LSB;
  - bits 13–23 → `fb_prog_o`, with bit 13 as the LSB.
- R6: A load leaves unchanged the three latch sets it does not address.
- R7: A reference load whose ratio is below 3 leaves the addressed set unchanged and sets `load_err_o`.
- R8: A feedback load whose program count is below 3, or whose swallow count is not below the program count, leaves the addressed set unchanged and sets `load_err_o`.
- R9: `load_err_o` changes only on a load. An accepted load clears it, and a refused load sets it.
- R10: Shifting without a rising load edge changes no latched output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_load_i | input | 1 | Load strobe, asynchronous |
| ref_ratio_o | output | 28 | Reference ratio, 14 bits per channel |
| ref_mon_o | output | 4 | Monitor select pair, 2 bits per channel |
| ref_cs_o | output | 2 | Charge-pump current select per channel |
| fb_swallow_o | output | 14 | Swallow count, 7 bits per channel |
| fb_prog_o | output | 22 | Program count, 11 bits per channel |
| fb_lds_o | output | 2 | Lock-detect/monitor select per channel |
| fb_presc_o | output | 2 | Prescaler modulus select per channel |
| fb_phase_o | output | 2 | Phase-control bit per channel |
| load_err_o | output | 1 | Last load was refused |

## Verification
The bench sweeps reference ratios 0 to 40 plus the two top codes, and feedback pairs with program count 0 to 12 against swallow count 0 to 13, on every address. This covers:
- the floor of 3, where a design that used the wrong comparison would accept ratio 2 or refuse ratio 3;
- the boundary where swallow equals program, which a design using less-or-equal would accept.

After every load, all four sets are compared. A decoder that swapped the two control bits, or wrote more than one set, shows up as corruption in a set that was not addressed.

Further checks cover three cases:
- A 25-bit burst detects a register that is too long or that shifts the wrong way.
- Shifting with no load detects a design that latches on serial-clock edges.
- Don't-care bits filled with a pattern detect an off-by-one field slice.

// File: rtl/cfgld_pkg.sv
// Package: word geometry, field bit positions and decode helpers shared by
// the serial configuration loader. Bit positions are 0-based positions in
// the shift register; word bit k sits at register position k-1.
package cfgld_pkg;

    localparam int WORD_W    = 23;
    localparam int CH_BITS   = 1;
    localparam int NUM_CH    = 2 ** CH_BITS;
    localparam int REF_W     = 14;
    localparam int SWL_W     = 7;
    localparam int PRG_W     = 11;
    localparam int MON_W     = 2;
    localparam int MIN_COUNT = 3;

    // Address bits, common to both layouts
    localparam int POS_CH   = 0;
    localparam int POS_KIND = 1;

    // Reference layout
    localparam int POS_MON_LO = 2;
    localparam int POS_REF_LO = POS_MON_LO + MON_W;
    localparam int POS_CS     = POS_REF_LO + REF_W;

    // Feedback layout
    localparam int POS_LDS    = 2;
    localparam int POS_PRESC  = 3;
    localparam int POS_PHASE  = 4;
    localparam int POS_SWL_LO = 5;
    localparam int POS_PRG_LO = POS_SWL_LO + SWL_W;

    typedef struct packed {
        logic [REF_W-1:0] ratio;
        logic [MON_W-1:0] mon;
        logic             cs;
    } ref_cfg_t;

    typedef struct packed {
        logic [PRG_W-1:0] prog;
        logic [SWL_W-1:0] swallow;
        logic             lds;
        logic             presc;
        logic             phase;
    } fb_cfg_t;

    // Extract reference fields from the used part of the word
    function automatic ref_cfg_t unpack_ref(input logic [POS_CS:POS_MON_LO] f);
        ref_cfg_t c;
        c.ratio = f[POS_REF_LO +: REF_W];
        c.mon   = f[POS_MON_LO +: MON_W];
        c.cs    = f[POS_CS];
        return c;
    endfunction

    // Extract feedback fields from the word above the address bits
    function automatic fb_cfg_t unpack_fb(input logic [WORD_W-1:POS_LDS] f);
        fb_cfg_t c;
        c.prog    = f[POS_PRG_LO +: PRG_W];
        c.swallow = f[POS_SWL_LO +: SWL_W];
        c.lds     = f[POS_LDS];
        c.presc   = f[POS_PRESC];
        c.phase   = f[POS_PHASE];
        return c;
    endfunction

    // Reference ratio legality
    function automatic logic ref_legal(input ref_cfg_t c);
        return c.ratio >= REF_W'(MIN_COUNT);
    endfunction

    // Feedback counts legality: program floor and swallow below program
    function automatic logic fb_legal(input fb_cfg_t c);
        return (c.prog >= PRG_W'(MIN_COUNT)) && (PRG_W'(c.swallow) < c.prog);
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
// Module: multi-lane synchronizer.
// Carries a group of asynchronous single-bit inputs into the clk domain
// through STAGES flip-flops per lane. Assumes every input is held for longer
// than STAGES+1 clk periods, so no edge is lost.
module cfgld_sync #(
    parameter int STAGES = 2,
    parameter int LANES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_i,
    output logic [LANES-1:0] sync_o
);

    logic [STAGES-1:0][LANES-1:0] pipe_q;

    // Shift each lane through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/cfgld_shifter.sv
// Module: serial-in shift register.
// Moves one bit in at position 0 on each shift strobe; older bits move
// toward the top, so the first bit sent ends at position W-1.
// Assumes shift_en is a single-cycle strobe in the clk domain.
module cfgld_shifter #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_o
);

    // Accept one bit per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (shift_en) begin
            word_o <= {word_o[W-2:0], din};
        end
    end

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_o[0] == $past(din))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word_o)); // R10

endmodule

// File: rtl/cfgld_chan_latch.sv
// Module: latch sets for one synthesizer channel.
// Holds a reference set and a feedback set. On a load strobe whose channel
// bit equals CH_ID, the set named by the kind bit is written, but only if its
// decoded values are legal; otherwise reject_o is raised for that cycle.
// Assumes load_stb is a single-cycle strobe and word_i is stable around it.
module cfgld_chan_latch
    import cfgld_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [WORD_W-1:0] word_i,
    output ref_cfg_t          ref_o,
    output fb_cfg_t           fb_o,
    output logic              reject_o
);

    ref_cfg_t ref_next;
    fb_cfg_t  fb_next;
    logic     ch_match;
    logic     ref_hit;
    logic     fb_hit;
    logic     ref_ok;
    logic     fb_ok;

    // Decode address and candidate fields
    always_comb begin
        ref_next = unpack_ref(word_i[POS_CS:POS_MON_LO]);
        fb_next  = unpack_fb(word_i[WORD_W-1:POS_LDS]);
        ch_match = (word_i[POS_CH +: CH_BITS] == CH_BITS'(CH_ID));
        ref_hit  = load_stb && ch_match && !word_i[POS_KIND];
        fb_hit   = load_stb && ch_match &&  word_i[POS_KIND];
        ref_ok   = ref_legal(ref_next);
        fb_ok    = fb_legal(fb_next);
        reject_o = (ref_hit && !ref_ok) || (fb_hit && !fb_ok);
    end

    // Reference set update on an accepted reference load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_o <= '0;
        end else if (ref_hit && ref_ok) begin
            ref_o <= ref_next;
        end
    end

    // Feedback set update on an accepted feedback load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_o <= '0;
        end else if (fb_hit && fb_ok) begin
            fb_o <= fb_next;
        end
    end

    AST_REF_UNADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_hit |=> $stable(ref_o)); // R6

    AST_FB_UNADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_hit |=> $stable(fb_o)); // R6

    AST_REF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_o.ratio == '0) || (ref_o.ratio >= REF_W'(MIN_COUNT))); // R7

    AST_FB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_o.prog == '0) || ((fb_o.prog >= PRG_W'(MIN_COUNT)) &&
                              (PRG_W'(fb_o.swallow) < fb_o.prog))); // R8

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |=> ($stable(ref_o) && $stable(fb_o))); // R7

endmodule

// File: rtl/cfg_serial_loader.sv
// Module: three-wire serial configuration loader (top).
// Synchronizes data, serial clock and load strobe and detects their rising
// edges. It shifts bits into the word register and routes each load to one
// of the per-channel latch sets. The error flag keeps the outcome of the
// latest load. Assumes each serial level is held for several clk periods.
module cfg_serial_loader
    import cfgld_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_clk_i,
    input  logic                      ser_data_i,
    input  logic                      ser_load_i,
    output logic [NUM_CH*REF_W-1:0]   ref_ratio_o,
    output logic [NUM_CH*MON_W-1:0]   ref_mon_o,
    output logic [NUM_CH-1:0]         ref_cs_o,
    output logic [NUM_CH*SWL_W-1:0]   fb_swallow_o,
    output logic [NUM_CH*PRG_W-1:0]   fb_prog_o,
    output logic [NUM_CH-1:0]         fb_lds_o,
    output logic [NUM_CH-1:0]         fb_presc_o,
    output logic [NUM_CH-1:0]         fb_phase_o,
    output logic                      load_err_o
);

    localparam int LANES  = 3;
    localparam int L_DATA = 0;
    localparam int L_SCLK = 1;
    localparam int L_LOAD = 2;

    logic [LANES-1:0]  lvl;
    logic              sclk_prev_q;
    logic              load_prev_q;
    logic              shift_stb;
    logic              load_stb;
    logic [WORD_W-1:0] word;
    logic [NUM_CH-1:0] reject;

    cfgld_sync #(
        .STAGES (SYNC_STAGES),
        .LANES  (LANES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_load_i, ser_clk_i, ser_data_i}),
        .sync_o  (lvl)
    );

    // Remember the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            load_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= lvl[L_SCLK];
            load_prev_q <= lvl[L_LOAD];
        end
    end

    assign shift_stb = lvl[L_SCLK] && !sclk_prev_q;
    assign load_stb  = lvl[L_LOAD] && !load_prev_q;

    cfgld_shifter #(
        .W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_stb),
        .din      (lvl[L_DATA]),
        .word_o   (word)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ref_cfg_t ref_q;
        fb_cfg_t  fb_q;

        cfgld_chan_latch #(
            .CH_ID (c)
        ) u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_stb (load_stb),
            .word_i   (word),
            .ref_o    (ref_q),
            .fb_o     (fb_q),
            .reject_o (reject[c])
        );

        assign ref_ratio_o[c*REF_W +: REF_W]  = ref_q.ratio;
        assign ref_mon_o[c*MON_W +: MON_W]    = ref_q.mon;
        assign ref_cs_o[c]                    = ref_q.cs;
        assign fb_swallow_o[c*SWL_W +: SWL_W] = fb_q.swallow;
        assign fb_prog_o[c*PRG_W +: PRG_W]    = fb_q.prog;
        assign fb_lds_o[c]                    = fb_q.lds;
        assign fb_presc_o[c]                  = fb_q.presc;
        assign fb_phase_o[c]                  = fb_q.phase;
    end

    // Record whether the latest load was refused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_err_o <= 1'b0;
        end else if (load_stb) begin
            load_err_o <= |reject;
        end
    end

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(load_err_o)); // R9

    AST_REJECT_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |-> (reject == '0)); // R6

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb); // R3

    AST_ONE_REJECTER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reject)); // R3

endmodule

// File: tb/cfg_serial_loader_bench.sv
// Bench: sweeps divider values on every address and compares all outputs
// with a model built from the requirements after each load.
module cfg_serial_loader_bench;
    import cfgld_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b0;

    logic [NUM_CH*REF_W-1:0] ref_ratio_o;
    logic [NUM_CH*MON_W-1:0] ref_mon_o;
    logic [NUM_CH-1:0]       ref_cs_o;
    logic [NUM_CH*SWL_W-1:0] fb_swallow_o;
    logic [NUM_CH*PRG_W-1:0] fb_prog_o;
    logic [NUM_CH-1:0]       fb_lds_o;
    logic [NUM_CH-1:0]       fb_presc_o;
    logic [NUM_CH-1:0]       fb_phase_o;
    logic                    load_err_o;

    always #4 clk = ~clk;

    cfg_serial_loader u_cfg_serial_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk_i    (ser_clk),
        .ser_data_i   (ser_data),
        .ser_load_i   (ser_load),
        .ref_ratio_o  (ref_ratio_o),
        .ref_mon_o    (ref_mon_o),
        .ref_cs_o     (ref_cs_o),
        .fb_swallow_o (fb_swallow_o),
        .fb_prog_o    (fb_prog_o),
        .fb_lds_o     (fb_lds_o),
        .fb_presc_o   (fb_presc_o),
        .fb_phase_o   (fb_phase_o),
        .load_err_o   (load_err_o)
    );

    int  vectors = 0;
    int  miscompares = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    // Expected state
    logic [REF_W-1:0] e_ratio [NUM_CH];
    logic [MON_W-1:0] e_mon   [NUM_CH];
    logic             e_cs    [NUM_CH];
    logic [SWL_W-1:0] e_swl   [NUM_CH];
    logic [PRG_W-1:0] e_prg   [NUM_CH];
    logic             e_lds   [NUM_CH];
    logic             e_presc [NUM_CH];
    logic             e_phase [NUM_CH];
    logic             e_err;

    // Watchdog: counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000 && !done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer than %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(input string req, input string what, input int ch,
                             input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s ch%0d: actual %0d expected %0d", req, what, ch, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NUM_CH; c++) begin
            check_val(req, "ref_ratio", c, 32'(ref_ratio_o[c*REF_W +: REF_W]), 32'(e_ratio[c]));
            check_val(req, "ref_mon",   c, 32'(ref_mon_o[c*MON_W +: MON_W]),   32'(e_mon[c]));
            check_val(req, "ref_cs",    c, 32'(ref_cs_o[c]),                   32'(e_cs[c]));
            check_val(req, "fb_swallow",c, 32'(fb_swallow_o[c*SWL_W +: SWL_W]),32'(e_swl[c]));
            check_val(req, "fb_prog",   c, 32'(fb_prog_o[c*PRG_W +: PRG_W]),   32'(e_prg[c]));
            check_val(req, "fb_lds",    c, 32'(fb_lds_o[c]),                   32'(e_lds[c]));
            check_val(req, "fb_presc",  c, 32'(fb_presc_o[c]),                 32'(e_presc[c]));
            check_val(req, "fb_phase",  c, 32'(fb_phase_o[c]),                 32'(e_phase[c]));
        end
        check_val(req, "load_err", 0, 32'(load_err_o), 32'(e_err));
    endtask

    // Send n bits, top bit first
    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
        end
        wait_clk(3);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        wait_clk(5);
        ser_load = 1'b0;
        wait_clk(5);
    endtask

    // Model from R3..R9: address by bits 2,1 and refuse illegal values
    task automatic model_load(input logic [WORD_W-1:0] w);
        int c;
        c = int'(w[0]);
        if (!w[1]) begin
            if (w[17:4] >= 14'd3) begin
                e_ratio[c] = w[17:4];
                e_mon[c]   = w[3:2];
                e_cs[c]    = w[18];
                e_err      = 1'b0;
            end else begin
                e_err = 1'b1;
            end
        end else begin
            if (w[22:12] >= 11'd3 && {4'd0, w[11:5]} < w[22:12]) begin
                e_prg[c]   = w[22:12];
                e_swl[c]   = w[11:5];
                e_phase[c] = w[4];
                e_presc[c] = w[3];
                e_lds[c]   = w[2];
                e_err      = 1'b0;
            end else begin
                e_err = 1'b1;
            end
        end
    endtask

    task automatic send_word(input logic [WORD_W-1:0] w);
        shift_bits(32'(w), WORD_W);
        pulse_load();
        model_load(w);
    endtask

    function automatic logic [WORD_W-1:0] ref_word(input int ch, input int r);
        logic [13:0] rv;
        rv = 14'(r);
        return {rv[6:3], rv[2], rv, rv[1] ^ ch[0], rv[0], 1'b0, ch[0]};
    endfunction

    function automatic logic [WORD_W-1:0] fb_word(input int ch, input int n, input int a);
        logic [10:0] nv;
        logic [6:0]  av;
        nv = 11'(n);
        av = 7'(a);
        return {nv, av, av[1] ^ nv[1], nv[0] ^ ch[0], av[0], 1'b1, ch[0]};
    endfunction

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            e_ratio[c] = '0; e_mon[c] = '0; e_cs[c] = 1'b0;
            e_swl[c] = '0; e_prg[c] = '0;
            e_lds[c] = 1'b0; e_presc[c] = 1'b0; e_phase[c] = 1'b0;
        end
        e_err = 1'b0;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R1");

        // R3/R6: each of the four addresses, others must hold
        send_word(ref_word(0, 1234)); check_all("R3/R6");
        send_word(ref_word(1, 9876)); check_all("R3/R6");
        send_word(fb_word(0, 700, 45)); check_all("R3/R6");
        send_word(fb_word(1, 2047, 127)); check_all("R3/R6");

        // R4 and R7: reference ratio sweep around the floor and at the top
        for (int c = 0; c < NUM_CH; c++) begin
            for (int r = 0; r <= 40; r++) begin
                send_word(ref_word(c, r));
                check_all(r < 3 ? "R7" : "R4");
            end
            send_word(ref_word(c, 16383)); check_all("R4");
            send_word(ref_word(c, 16382)); check_all("R4");
        end

        // R5 and R8: feedback pairs including swallow == program
        for (int c = 0; c < NUM_CH; c++) begin
            for (int n = 0; n <= 12; n++) begin
                for (int a = 0; a <= 13; a++) begin
                    send_word(fb_word(c, n, a));
                    check_all((n < 3 || a >= n) ? "R8" : "R5");
                end
            end
        end

        // R9: refused then accepted, and flag steady with no load
        send_word(ref_word(1, 2)); check_all("R9");
        wait_clk(20); check_all("R9");
        send_word(ref_word(1, 3)); check_all("R9");

        // R10: shifting alone changes nothing; the later load applies it
        shift_bits(32'(ref_word(0, 5555)), WORD_W);
        wait_clk(10);
        check_all("R10");
        pulse_load();
        model_load(ref_word(0, 5555));
        check_all("R10");

        // R2: 25 bits sent, the two leading extra ones fall off the top
        shift_bits({7'd0, 2'b11, fb_word(1, 1000, 99)}, WORD_W + 2);
        pulse_load();
        model_load(fb_word(1, 1000, 99));
        check_all("R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule